// File: doc/BRIEF.md
# Masked-Compare Timer with PWM Output and Edge Capture

This peripheral runs a free-running up-counter that advances on a clock-enable input. It detects two events on that counter. A compare event occurs when the counter and a compare value agree in every bit that a mask register selects. A zero event occurs when every bit that the mask selects in the counter is zero. Either event can drive a single PWM pin, in one of two modes. In set/reset mode a zero event raises the pin and a compare event drops it. In toggle mode each compare event inverts the pin.

A second input is synchronised, watched for a programmable edge, and on that edge the block stores the current counter value in a capture register. The three events each set a sticky status flag. Software can clear these flags but cannot set them. Each flag has an enable, and the enabled flags are ORed onto one interrupt line. Software uses a write port and a read port, each with a select code, to reach the mask, the compare value and an 8-bit control/status byte. The capture value and the counter can be read but not written.

The PWM pin is produced by a two-state machine with the states `ST_LOW` and `ST_HIGH`.
- The *raise* transition (`ST_LOW` to `ST_HIGH`) fires on a zero event without a compare event in set/reset mode, and on a compare event in toggle mode.
- The *drop* transition (`ST_HIGH` to `ST_LOW`) fires on any compare event.
- Otherwise each state holds.

Top module: `masked_cmp_timer`

## Requirements
- R1: The counter resets to 0. It rises by one on each clock edge where `cnt_en` is 1, holds where `cnt_en` is 0, and wraps from 0xFFFF to 0x0000.
- R2: When `(mask & count) == (mask & compare)` turns from false to true, control bit 3 (compare flag) is set on the next clock edge. While the match continues the flag is not set again.
- R3: When `(mask & count) == 0` turns from false to true, control bit 1 (zero flag) is set on the next edge. This also happens while the counter is held, for example after a mask write.
- R4: With control bit 0 = 0 (set/reset mode), `pwm_out` goes to 1 one edge after a zero event and to 0 one edge after a compare event. When both events occur in the same cycle, `pwm_out` goes to 0.
- R5: With control bit 0 = 1 (toggle mode), `pwm_out` inverts one edge after each compare event, and zero events leave it unchanged.
- R6: The capture input passes through a 2-flop synchroniser. Control bit 7 = 0 selects the falling edge and 1 selects the rising edge; the other edge is ignored. On the third clock edge after the input changes, the capture register loads the counter and control bit 5 (capture flag) is set.
- R7: A control write sets bits 7, 6, 4, 2 and 0 directly. For flag bits 5, 3 and 1, writing 0 clears the flag and writing 1 leaves it unchanged.
- R8: If a flag's event and a write that clears it land on the same edge, the flag ends up set.
- R9: `irq` = (bit5 & bit6) | (bit3 & bit4) | (bit1 & bit2) of the control byte, visible in the same cycle as the control byte.
- R10: Select codes are 0 mask, 1 compare, 2 control (in bits 7:0, upper bits read 0), 3 capture, and 4 counter. Other codes read 0. Writes to codes 3 to 7 have no effect. After reset the mask and compare registers read 0xFFFF and the control and capture registers read 0.
- R11: After reset `pwm_out` and `irq` are 0. A match that already holds when reset is released does not count as an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter advance enable |
| cap_in | input | 1 | Asynchronous capture input |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target select code |
| wr_data | input | 16 | Write data |
| rd_sel | input | 3 | Read select code |
| rd_data | output | 16 | Read data, combinational from `rd_sel` |
| pwm_out | output | 1 | PWM pin |
| irq | output | 1 | Combined interrupt |

## Verification
Timing of each result:
- A register write takes effect on the edge it is presented to, and any event it creates shows up one edge later in a flag and in `pwm_out`. The bench therefore reads the flags once on the edge before they are due, expecting them clear, and again on the due edge.
- A counter step shows up on the edge that takes it.
- A capture is due on the third edge after the input change. The bench checks the capture register and flag two edges after the change (still clear) and three edges after (loaded).
- `irq` follows the control byte without delay.

How the checks keep to that timing:
- Inputs are driven and outputs sampled at the falling clock edge.
- The counter is held still whenever a result depends on its value, so expected values follow directly from the requirements.

// File: rtl/mct_pkg.sv
`timescale 1ns/1ps
package mct_pkg;

    typedef enum logic [2:0] {
        SEL_MASK = 3'd0,
        SEL_CMP  = 3'd1,
        SEL_CTRL = 3'd2,
        SEL_CAP  = 3'd3,
        SEL_CNT  = 3'd4
    } reg_sel_e;

    // Field order is the register layout, bit 7 first.
    typedef struct packed {
        logic cap_rise;
        logic cap_ie;
        logic cap_fl;
        logic cmp_ie;
        logic cmp_fl;
        logic zero_ie;
        logic zero_fl;
        logic toggle;
    } ctrl_t;

    typedef enum logic {
        ST_LOW  = 1'b0,
        ST_HIGH = 1'b1
    } pwm_state_e;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/mct_counter.sv
`timescale 1ns/1ps
module mct_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         count_en,
    output logic [W-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (count_en) begin
            count <= count + W'(1);
        end
    end

endmodule

// File: rtl/mct_matcher.sv
`timescale 1ns/1ps
module mct_matcher #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] count,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] cmp_val,
    output logic         cmp_evt,
    output logic         zero_evt
);

    logic cmp_hit;
    logic zero_hit;
    logic cmp_hit_q;
    logic zero_hit_q;

    assign cmp_hit  = ((count ^ cmp_val) & mask) == '0;
    assign zero_hit = (count & mask) == '0;

    // Previous-cycle copies start at 1 so a match that holds at reset release is no event.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_hit_q  <= 1'b1;
            zero_hit_q <= 1'b1;
        end else begin
            cmp_hit_q  <= cmp_hit;
            zero_hit_q <= zero_hit;
        end
    end

    assign cmp_evt  = cmp_hit  & ~cmp_hit_q;
    assign zero_evt = zero_hit & ~zero_hit_q;

endmodule

// File: rtl/mct_capture.sv
`timescale 1ns/1ps
module mct_capture #(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pin,
    input  logic         rise_sel,
    input  logic [W-1:0] count,
    output logic         cap_evt,
    output logic [W-1:0] cap_val
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   seen_q;
    logic                   synced;

    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[i] <= 1'b0;
                else        sync_q[i] <= pin;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[i] <= 1'b0;
                else        sync_q[i] <= sync_q[i-1];
            end
        end
    end

    assign synced = sync_q[LAST];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= synced;
    end

    assign cap_evt = rise_sel ? (synced & ~seen_q) : (~synced & seen_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_val <= '0;
        end else if (cap_evt) begin
            cap_val <= count;
        end
    end

endmodule

// File: rtl/mct_pwm.sv
`timescale 1ns/1ps
module mct_pwm
    import mct_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic toggle_mode,
    input  logic zero_evt,
    input  logic cmp_evt,
    output logic pwm
);

    pwm_state_e st_q;
    pwm_state_e st_d;
    logic       raise;

    // Set/reset mode: zero raises, compare drops and wins a tie. Toggle mode: compare flips.
    assign raise = toggle_mode ? cmp_evt : (zero_evt & ~cmp_evt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_LOW;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_LOW:  if (raise)   st_d = ST_HIGH;
            ST_HIGH: if (cmp_evt) st_d = ST_LOW;
            default: st_d = ST_LOW;
        endcase
    end

    always_comb begin
        pwm = (st_q == ST_HIGH);
    end

endmodule

// File: rtl/masked_cmp_timer.sv
`timescale 1ns/1ps
module masked_cmp_timer
    import mct_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             cap_in,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [2:0]       rd_sel,
    output logic [CNT_W-1:0] rd_data,
    output logic             pwm_out,
    output logic             irq
);

    localparam int PAD_W = CNT_W - CTRL_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask_q;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] cap_val;
    ctrl_t            ctrl_q;
    ctrl_t            ctrl_d;
    ctrl_t            wr_ctrl;
    logic             cmp_evt;
    logic             zero_evt;
    logic             cap_evt;
    logic             ctrl_wr;

    mct_counter #(.W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (cnt_en),
        .count    (cnt_q)
    );

    mct_matcher #(.W(CNT_W)) u_matcher (
        .clk      (clk),
        .rst_n    (rst_n),
        .count    (cnt_q),
        .mask     (mask_q),
        .cmp_val  (cmp_q),
        .cmp_evt  (cmp_evt),
        .zero_evt (zero_evt)
    );

    mct_capture #(.W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (cap_in),
        .rise_sel (ctrl_q.cap_rise),
        .count    (cnt_q),
        .cap_evt  (cap_evt),
        .cap_val  (cap_val)
    );

    mct_pwm u_pwm (
        .clk         (clk),
        .rst_n       (rst_n),
        .toggle_mode (ctrl_q.toggle),
        .zero_evt    (zero_evt),
        .cmp_evt     (cmp_evt),
        .pwm         (pwm_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
            cmp_q  <= '1;
        end else if (wr_en) begin
            if (wr_sel == SEL_MASK) mask_q <= wr_data;
            if (wr_sel == SEL_CMP)  cmp_q  <= wr_data;
        end
    end

    assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
    assign wr_ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);

    // Flags: a written 0 clears, a written 1 keeps; a hardware event overrides a clear.
    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_wr) begin
            ctrl_d.cap_rise = wr_ctrl.cap_rise;
            ctrl_d.cap_ie   = wr_ctrl.cap_ie;
            ctrl_d.cmp_ie   = wr_ctrl.cmp_ie;
            ctrl_d.zero_ie  = wr_ctrl.zero_ie;
            ctrl_d.toggle   = wr_ctrl.toggle;
            ctrl_d.cap_fl   = ctrl_q.cap_fl  & wr_ctrl.cap_fl;
            ctrl_d.cmp_fl   = ctrl_q.cmp_fl  & wr_ctrl.cmp_fl;
            ctrl_d.zero_fl  = ctrl_q.zero_fl & wr_ctrl.zero_fl;
        end
        if (cap_evt)  ctrl_d.cap_fl  = 1'b1;
        if (cmp_evt)  ctrl_d.cmp_fl  = 1'b1;
        if (zero_evt) ctrl_d.zero_fl = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign irq = (ctrl_q.cap_fl  & ctrl_q.cap_ie)
               | (ctrl_q.cmp_fl  & ctrl_q.cmp_ie)
               | (ctrl_q.zero_fl & ctrl_q.zero_ie);

    always_comb begin
        case (rd_sel)
            SEL_MASK: rd_data = mask_q;
            SEL_CMP:  rd_data = cmp_q;
            SEL_CTRL: rd_data = {{PAD_W{1'b0}}, ctrl_q};
            SEL_CAP:  rd_data = cap_val;
            SEL_CNT:  rd_data = cnt_q;
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/mct_checker.sv
`timescale 1ns/1ps
module mct_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cnt_en,
    input logic [W-1:0] cnt,
    input logic [7:0]   ctrl,
    input logic         cmp_evt,
    input logic         zero_evt,
    input logic         cap_evt,
    input logic [W-1:0] cap_val,
    input logic         pwm_out,
    input logic         irq
);

    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en |=> cnt == $past(cnt) + W'(1));

    p_count_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(cnt));

    p_cmp_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_evt |=> ctrl[3]);

    p_zero_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |=> ctrl[1]);

    p_pwm_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_evt && !cmp_evt && !ctrl[0]) |=> pwm_out);

    p_pwm_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_evt && !ctrl[0]) |=> !pwm_out);

    p_pwm_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_evt && ctrl[0]) |=> pwm_out != $past(pwm_out));

    p_cap_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (cap_val == $past(cnt)) && ctrl[5]);

    p_cmp_flag_hw_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl[3]) |-> $past(cmp_evt));

    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[5] && !ctrl[3] && !ctrl[1]) |-> !irq);

    p_irq_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[5] && ctrl[6]) |-> irq);

endmodule

bind masked_cmp_timer mct_checker #(.W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_en   (cnt_en),
    .cnt      (cnt_q),
    .ctrl     (ctrl_q),
    .cmp_evt  (cmp_evt),
    .zero_evt (zero_evt),
    .cap_evt  (cap_evt),
    .cap_val  (cap_val),
    .pwm_out  (pwm_out),
    .irq      (irq)
);

// File: tb/masked_cmp_timer_tb.sv
`timescale 1ns/1ps
module masked_cmp_timer_tb;

    localparam int W = 16;
    localparam logic [2:0] S_MASK = 3'd0;
    localparam logic [2:0] S_CMP  = 3'd1;
    localparam logic [2:0] S_CTRL = 3'd2;
    localparam logic [2:0] S_CAP  = 3'd3;
    localparam logic [2:0] S_CNT  = 3'd4;

    logic         clk     = 1'b0;
    logic         rst_n   = 1'b0;
    logic         cnt_en  = 1'b0;
    logic         cap_in  = 1'b0;
    logic         wr_en   = 1'b0;
    logic [2:0]   wr_sel  = 3'd0;
    logic [W-1:0] wr_data = '0;
    logic [2:0]   rd_sel  = 3'd0;
    logic [W-1:0] rd_data;
    logic         pwm_out;
    logic         irq;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    masked_cmp_timer u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_en  (cnt_en),
        .cap_in  (cap_in),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .pwm_out (pwm_out),
        .irq     (irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_reg(input string req, input logic [2:0] sel, input logic [W-1:0] exp);
        rd_sel = sel;
        #1;
        chk(req, $sformatf("read sel %0d", sel), rd_data, exp);
    endtask

    task automatic chk_pwm(input string req, input logic exp);
        chk(req, "pwm_out", {{(W-1){1'b0}}, pwm_out}, {{(W-1){1'b0}}, exp});
    endtask

    task automatic chk_irq(input string req, input logic exp);
        chk(req, "irq", {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, exp});
    endtask

    task automatic wr(input logic [2:0] sel, input logic [W-1:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step(input int n);
        @(negedge clk);
        cnt_en = 1'b1;
        repeat (n) @(negedge clk);
        cnt_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        chk_reg("R10", S_MASK, 16'hFFFF);
        chk_reg("R10", S_CMP,  16'hFFFF);
        chk_reg("R10", S_CTRL, 16'h0000);
        chk_reg("R10", S_CAP,  16'h0000);
        chk_reg("R1",  S_CNT,  16'h0000);
        chk_pwm("R11", 1'b0);
        chk_irq("R11", 1'b0);
        idle(3);
        chk_reg("R11", S_CTRL, 16'h0000);
    endtask

    task automatic t_count;
        step(5);
        chk_reg("R1", S_CNT, 16'd5);
        idle(3);
        chk_reg("R1", S_CNT, 16'd5);
        step(65530);
        chk_reg("R1", S_CNT, 16'hFFFF);
        step(1);
        chk_reg("R1", S_CNT, 16'h0000);
        wr(S_CTRL, 16'h0000);
        chk_reg("R7", S_CTRL, 16'h0000);
        chk_pwm("R4", 1'b1);
    endtask

    task automatic t_compare;
        wr(S_MASK, 16'h00F0);
        wr(S_CMP,  16'h1234);
        idle(1);
        chk_reg("R2", S_CTRL, 16'h0000);
        wr(S_CMP, 16'hAB05);
        chk_reg("R2", S_CTRL, 16'h0000);
        idle(1);
        chk_reg("R2", S_CTRL, 16'h0008);
        chk_pwm("R4", 1'b0);
        wr(S_CTRL, 16'h0000);
        idle(3);
        chk_reg("R2", S_CTRL, 16'h0000);
    endtask

    task automatic t_zero_hold;
        wr(S_MASK, 16'hFFFF);
        step(5);
        chk_reg("R3", S_CTRL, 16'h0000);
        wr(S_MASK, 16'hFFF0);
        idle(1);
        chk_reg("R3", S_CTRL, 16'h0002);
        chk_reg("R3", S_CNT, 16'd5);
        chk_pwm("R4", 1'b1);
    endtask

    task automatic t_pwm_setreset;
        wr(S_MASK, 16'hFFFF);
        wr(S_CMP,  16'h0009);
        step(4);
        chk_pwm("R4", 1'b1);
        idle(1);
        chk_pwm("R4", 1'b0);
        wr(S_MASK, 16'hFFF0);
        idle(1);
        chk_pwm("R4", 1'b1);
        wr(S_MASK, 16'hFFFF);
        wr(S_CMP,  16'h000C);
        step(3);
        idle(1);
        chk_pwm("R4", 1'b0);
        wr(S_MASK, 16'hFFF0);
        idle(1);
        chk_pwm("R4", 1'b1);
        wr(S_MASK, 16'hFFFF);
        wr(S_CMP,  16'h001C);
        wr(S_MASK, 16'hFFE0);
        idle(1);
        chk_pwm("R4", 1'b0);
    endtask

    task automatic t_toggle;
        wr(S_MASK, 16'hFFFF);
        wr(S_CTRL, 16'h0001);
        wr(S_CMP,  16'h000C);
        idle(1);
        chk_pwm("R5", 1'b1);
        wr(S_CMP, 16'h0000);
        wr(S_CMP, 16'h000C);
        idle(1);
        chk_pwm("R5", 1'b0);
        wr(S_MASK, 16'hFFF0);
        idle(2);
        chk_pwm("R5", 1'b0);
        wr(S_MASK, 16'hFFFF);
        wr(S_CMP,  16'h0000);
        wr(S_CMP,  16'h000C);
        idle(1);
        chk_pwm("R5", 1'b1);
        wr(S_MASK, 16'hFFF0);
    endtask

    task automatic t_capture;
        wr(S_CTRL, 16'h0000);
        @(negedge clk); cap_in = 1'b1;
        idle(4);
        chk_reg("R6", S_CAP,  16'h0000);
        chk_reg("R6", S_CTRL, 16'h0000);
        @(negedge clk); cap_in = 1'b0;
        idle(2);
        chk_reg("R6", S_CAP,  16'h0000);
        idle(1);
        chk_reg("R6", S_CAP,  16'd12);
        chk_reg("R6", S_CTRL, 16'h0020);
        step(8);
        wr(S_CTRL, 16'h0080);
        @(negedge clk); cap_in = 1'b1;
        idle(3);
        chk_reg("R6", S_CAP,  16'd20);
        chk_reg("R6", S_CTRL, 16'h00A0);
        step(2);
        wr(S_CTRL, 16'h0080);
        @(negedge clk); cap_in = 1'b0;
        idle(4);
        chk_reg("R6", S_CAP,  16'd20);
        chk_reg("R6", S_CTRL, 16'h0080);
    endtask

    task automatic t_flags;
        @(negedge clk); cap_in = 1'b1;
        idle(3);
        chk_reg("R6", S_CAP, 16'd22);
        wr(S_CTRL, 16'h00FF);
        chk_reg("R7", S_CTRL, 16'h00F5);
        chk_irq("R9", 1'b1);
        wr(S_CTRL, 16'h00D5);
        chk_reg("R7", S_CTRL, 16'h00D5);
        chk_irq("R9", 1'b0);
    endtask

    task automatic t_irq;
        wr(S_CTRL, 16'h0080);
        wr(S_CMP,  16'h0016);
        idle(1);
        chk_reg("R2", S_CTRL, 16'h0088);
        chk_irq("R9", 1'b0);
        wr(S_CTRL, 16'h0098);
        chk_irq("R9", 1'b1);
        wr(S_CTRL, 16'h0090);
        chk_irq("R9", 1'b0);
        wr(S_MASK, 16'h0001);
        idle(1);
        chk_reg("R3", S_CTRL, 16'h0092);
        chk_irq("R9", 1'b0);
        wr(S_CTRL, 16'h0006);
        chk_reg("R7", S_CTRL, 16'h0006);
        chk_irq("R9", 1'b1);
    endtask

    task automatic race_capture;
        @(negedge clk); cap_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = S_CTRL; wr_data = 16'h0000;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_race;
        wr(S_CTRL, 16'h0000);
        race_capture();
        chk_reg("R8", S_CTRL, 16'h0020);
        chk_reg("R8", S_CAP,  16'd22);
        @(negedge clk); cap_in = 1'b1;
        idle(4);
        chk_reg("R8", S_CTRL, 16'h0020);
        race_capture();
        chk_reg("R8", S_CTRL, 16'h0020);
        wr(S_CTRL, 16'h0000);
        chk_reg("R7", S_CTRL, 16'h0000);
    endtask

    task automatic t_regs;
        wr(S_CAP, 16'h1234);
        chk_reg("R10", S_CAP, 16'd22);
        wr(S_CNT, 16'h7777);
        chk_reg("R10", S_CNT, 16'd22);
        wr(S_MASK, 16'hA5A5);
        chk_reg("R10", S_MASK, 16'hA5A5);
        wr(S_CMP, 16'h5A5A);
        chk_reg("R10", S_CMP, 16'h5A5A);
        chk_reg("R10", 3'd5, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_count();
        t_compare();
        t_zero_hold();
        t_pwm_setreset();
        t_toggle();
        t_capture();
        t_flags();
        t_irq();
        t_race();
        t_regs();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule